// File: doc/BRIEF.md
# Interlace-capable raster scan controller

This block sweeps a raster display and produces frame-buffer read addresses, pixel coordinates, blanking and sync strobes. Each line has `H_VIS` visible pixel positions, left to right, followed by `H_RET` horizontal retrace cycles. Lines go top to bottom. After the last visible line of a field come `V_RET` retrace lines, each the full line length. During retrace no pixel is read and the colour output is forced to black.

The `interlace_en` input picks the line order for a whole frame. In progressive order a field is a full frame of `V_VIS` lines. In interlaced order an even field (lines 0, 2, 4, ...) is followed by an odd field (lines 1, 3, 5, ...). Each field then has `V_VIS/2` lines, so fields come twice as often for the same line timing.

The frame buffer answers each read one cycle later with a narrow pixel index on `fb_data`. All timing outputs are delayed one cycle so that they line up with that index. The index picks one entry of an 8-entry, 24-bit palette, and a host port can rewrite the palette at any time.

A three-state machine drives the sweep:
- `ST_ACTIVE` covers the visible positions of a line. It moves to `ST_HRET` on the last visible position.
- `ST_HRET` is the horizontal retrace. At the end of the line it returns to `ST_ACTIVE`, or goes to `ST_VRET` after the last line of the field.
- `ST_VRET` counts the retrace lines. At the end of the last one it goes back to `ST_ACTIVE` at the top of a new field.

Reset places the machine on the final cycle of `ST_VRET`, so the first clock after reset starts a frame.

Top module: `raster_scan_ctrl`

## Requirements
- R1: During reset the outputs are: `blank`=1, `hsync`=0, `vsync`=0, `rgb`=0 and `fb_rd_en`=0. Each palette entry i resets to grey level i*36 in all three channels. The channel order is red [23:16], green [15:8], blue [7:0].
- R2: Within a line, x runs from 0 to `H_VIS-1` on consecutive cycles, followed by `H_RET` retrace cycles. `fb_rd_en` is high exactly on visible positions, and `fb_addr` = y*`H_VIS` + x.
- R3: During horizontal retrace the output is blanked and nothing is read. `hsync` is high for line positions `H_VIS+1` to `H_VIS+H_RET-2` and low elsewhere.
- R4: After the last visible line of a field come `V_RET` retrace lines of `H_VIS+H_RET` cycles each. They are fully blanked, `vsync` is high throughout them, and `hsync` keeps its per-line pulse.
- R5: In progressive order a field scans lines 0 to `V_VIS-1` in sequence, and `field_odd` is 0.
- R6: In interlaced order the fields alternate. The even field scans lines 0, 2, 4, ... with `field_odd`=0. The odd field scans lines 1, 3, 5, ... with `field_odd`=1. Each field holds `V_VIS/2` lines.
- R7: `interlace_en` is sampled only at a frame start. That is the end of vertical retrace after a progressive field or after an odd field, plus the first clock after reset. A change in the middle of a frame waits for the next frame.
- R8: `pix_x`, `pix_y`, `blank`, `hsync`, `vsync` and `field_odd` appear one cycle after the matching `fb_addr`, in the same cycle as the returned `fb_data`. `pix_x` and `pix_y` have meaning only while `blank`=0.
- R9: `rgb` equals the palette entry selected by `fb_data` while `blank`=0, and 0 while `blank`=1.
- R10: A palette write (`pal_we`=1 at a clock edge) stores `pal_wdata` in entry `pal_addr`. Pixels output from the next cycle onward use the new colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interlace_en | input | 1 | 1 selects interlaced order, 0 progressive; takes effect per frame |
| fb_addr | output | clog2(H_VIS*V_VIS) | Frame-buffer read address |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_data | input | IDX_W | Pixel index returned one cycle after the read |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | IDX_W | Palette entry to write |
| pal_wdata | input | 24 | Colour to write, red in the top byte |
| pix_x | output | clog2(H_VIS+H_RET) | Column of the current output pixel |
| pix_y | output | clog2(V_VIS) | Display line of the current output pixel |
| blank | output | 1 | High while in either retrace |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync, high during vertical retrace |
| field_odd | output | 1 | 1 during an odd interlaced field |
| rgb | output | 24 | Colour output, black while blanked |

## Verification
The bench builds the block with an 8x6 visible area, 4 retrace cycles per line, 2 retrace lines and a 3-bit index. A progressive field then lasts 96 cycles and an interlaced field 60 cycles. This makes it cheap to compare every cycle of seven consecutive fields against an arithmetic model, including both transitions between modes and the full even/odd parity chain. Mode changes are made in the middle of a field to show that they wait for the frame boundary. Palette writes land on a visible pixel, on the last pixel of a line and inside vertical retrace.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_HRET   = 2'd1,
        ST_VRET   = 2'd2
    } scan_state_e;

    localparam int CH_W  = 8;
    localparam int COL_W = 3 * CH_W;

endpackage

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int H_VIS = 8,
    parameter int V_VIS = 6,
    parameter int H_RET = 4,
    parameter int V_RET = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               mode_i,
    output logic [$clog2(H_VIS+H_RET)-1:0]     x_o,
    output logic [$clog2(V_VIS)-1:0]           y_o,
    output logic                               active_o,
    output logic                               hs_o,
    output logic                               vs_o,
    output logic                               odd_o,
    output logic                               rd_en_o,
    output logic [$clog2(H_VIS*V_VIS)-1:0]     addr_o
);

    localparam int LINE_LEN = H_VIS + H_RET;
    localparam int HALF_V   = V_VIS / 2;
    localparam int XW       = $clog2(LINE_LEN);
    localparam int YW       = $clog2(V_VIS);
    localparam int VRW      = $clog2(V_RET + 1);
    localparam int AW       = $clog2(H_VIS * V_VIS);

    scan_state_e    state_q, state_d;
    logic [XW-1:0]  x_q;
    logic [YW-1:0]  row_q;
    logic [VRW-1:0] vrow_q;
    logic           odd_q;
    logic           ilace_q;

    logic           end_of_line;
    logic           last_row;
    logic           last_vrow;
    logic [YW-1:0]  line_y;

    assign end_of_line = (x_q == XW'(LINE_LEN - 1));
    assign last_vrow   = (vrow_q == VRW'(V_RET - 1));
    assign last_row    = ilace_q ? (row_q == YW'(HALF_V - 1))
                                 : (row_q == YW'(V_VIS - 1));

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (x_q == XW'(H_VIS - 1)) state_d = ST_HRET;
            ST_HRET:   if (end_of_line) state_d = last_row ? ST_VRET : ST_ACTIVE;
            ST_VRET:   if (end_of_line && last_vrow) state_d = ST_ACTIVE;
            default:   state_d = ST_VRET;
        endcase
    end

    // state register and sweep counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_VRET;
            x_q     <= XW'(LINE_LEN - 1);
            row_q   <= '0;
            vrow_q  <= VRW'(V_RET - 1);
            odd_q   <= 1'b0;
            ilace_q <= 1'b0;
        end else begin
            state_q <= state_d;
            x_q     <= end_of_line ? '0 : x_q + 1'b1;
            if (state_q == ST_HRET && end_of_line && !last_row) begin
                row_q <= row_q + 1'b1;
            end
            if (state_q == ST_VRET && end_of_line) begin
                vrow_q <= last_vrow ? '0 : vrow_q + 1'b1;
                if (last_vrow) begin
                    row_q <= '0;
                    if (ilace_q && !odd_q) begin
                        odd_q <= 1'b1;
                    end else begin
                        odd_q   <= 1'b0;
                        ilace_q <= mode_i;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        line_y   = ilace_q ? ((row_q << 1) | YW'(odd_q)) : row_q;
        active_o = (state_q == ST_ACTIVE);
        rd_en_o  = active_o;
        addr_o   = AW'(int'(line_y) * H_VIS + int'(x_q));
        hs_o     = (x_q >= XW'(H_VIS + 1)) && (x_q <= XW'(H_VIS + H_RET - 2));
        vs_o     = (state_q == ST_VRET);
        odd_o    = odd_q;
        x_o      = x_q;
        y_o      = line_y;
    end

endmodule

// File: rtl/raster_align.sv
module raster_align #(
    parameter int XW = 4,
    parameter int YW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] x_i,
    input  logic [YW-1:0] y_i,
    input  logic          active_i,
    input  logic          hs_i,
    input  logic          vs_i,
    input  logic          odd_i,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic          blank_o,
    output logic          hs_o,
    output logic          vs_o,
    output logic          odd_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o     <= '0;
            y_o     <= '0;
            blank_o <= 1'b1;
            hs_o    <= 1'b0;
            vs_o    <= 1'b0;
            odd_o   <= 1'b0;
        end else begin
            x_o     <= x_i;
            y_o     <= y_i;
            blank_o <= !active_i;
            hs_o    <= hs_i;
            vs_o    <= vs_i;
            odd_o   <= odd_i;
        end
    end

endmodule

// File: rtl/raster_palette.sv
module raster_palette
    import raster_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [COL_W-1:0] wdata_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [COL_W-1:0] rgb_o
);

    localparam int DEPTH     = 2 ** IDX_W;
    localparam int GREY_STEP = (2 ** CH_W - 1) / (DEPTH - 1);

    logic [COL_W-1:0] pal_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pal_q[i] <= {3{CH_W'(i * GREY_STEP)}};
            end
        end else if (we_i) begin
            pal_q[waddr_i] <= wdata_i;
        end
    end

    assign rgb_o = pal_q[idx_i];

endmodule

// File: rtl/raster_scan_ctrl.sv
module raster_scan_ctrl
    import raster_pkg::*;
#(
    parameter int H_VIS = 8,
    parameter int V_VIS = 6,
    parameter int H_RET = 4,
    parameter int V_RET = 2,
    parameter int IDX_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               interlace_en,
    output logic [$clog2(H_VIS*V_VIS)-1:0]     fb_addr,
    output logic                               fb_rd_en,
    input  logic [IDX_W-1:0]                   fb_data,
    input  logic                               pal_we,
    input  logic [IDX_W-1:0]                   pal_addr,
    input  logic [23:0]                        pal_wdata,
    output logic [$clog2(H_VIS+H_RET)-1:0]     pix_x,
    output logic [$clog2(V_VIS)-1:0]           pix_y,
    output logic                               blank,
    output logic                               hsync,
    output logic                               vsync,
    output logic                               field_odd,
    output logic [23:0]                        rgb
);

    localparam int XW = $clog2(H_VIS + H_RET);
    localparam int YW = $clog2(V_VIS);

    logic [XW-1:0]    t_x;
    logic [YW-1:0]    t_y;
    logic             t_active, t_hs, t_vs, t_odd;
    logic [COL_W-1:0] pal_rgb;

    raster_timing #(
        .H_VIS(H_VIS), .V_VIS(V_VIS), .H_RET(H_RET), .V_RET(V_RET)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .mode_i(interlace_en),
        .x_o(t_x), .y_o(t_y), .active_o(t_active),
        .hs_o(t_hs), .vs_o(t_vs), .odd_o(t_odd),
        .rd_en_o(fb_rd_en), .addr_o(fb_addr)
    );

    raster_align #(.XW(XW), .YW(YW)) u_align (
        .clk(clk), .rst_n(rst_n),
        .x_i(t_x), .y_i(t_y), .active_i(t_active),
        .hs_i(t_hs), .vs_i(t_vs), .odd_i(t_odd),
        .x_o(pix_x), .y_o(pix_y), .blank_o(blank),
        .hs_o(hsync), .vs_o(vsync), .odd_o(field_odd)
    );

    raster_palette #(.IDX_W(IDX_W)) u_pal (
        .clk(clk), .rst_n(rst_n),
        .we_i(pal_we), .waddr_i(pal_addr), .wdata_i(pal_wdata),
        .idx_i(fb_data), .rgb_o(pal_rgb)
    );

    assign rgb = blank ? '0 : pal_rgb;

endmodule

// File: rtl/raster_scan_chk.sv
module raster_scan_chk #(
    parameter int AW = 6,
    parameter int XW = 4,
    parameter int YW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fb_rd_en,
    input logic [AW-1:0] fb_addr,
    input logic          blank,
    input logic          hsync,
    input logic          vsync,
    input logic          field_odd,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] pix_y
);

    // R8
    rd_then_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |=> !blank);

    // R3
    hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> blank);

    // R4
    vsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> blank);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rd_en && $past(fb_rd_en)) |-> (fb_addr == $past(fb_addr) + 1'b1));

    // R2
    x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && !$past(blank)) |->
        (pix_x == $past(pix_x) + 1'b1) && (pix_y == $past(pix_y)));

    // R6
    parity_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> $past(blank));

endmodule

bind raster_scan_ctrl raster_scan_chk #(
    .AW($clog2(H_VIS*V_VIS)), .XW($clog2(H_VIS+H_RET)), .YW($clog2(V_VIS))
) u_chk (
    .clk(clk), .rst_n(rst_n), .fb_rd_en(fb_rd_en), .fb_addr(fb_addr),
    .blank(blank), .hsync(hsync), .vsync(vsync), .field_odd(field_odd),
    .pix_x(pix_x), .pix_y(pix_y)
);

// File: tb/sim_raster_scan_ctrl.sv
module sim_raster_scan_ctrl;

    localparam int H_VIS = 8;
    localparam int V_VIS = 6;
    localparam int H_RET = 4;
    localparam int V_RET = 2;
    localparam int IDX_W = 3;
    localparam int LINE  = H_VIS + H_RET;
    localparam int XW    = $clog2(LINE);
    localparam int YW    = $clog2(V_VIS);
    localparam int AW    = $clog2(H_VIS * V_VIS);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n, interlace_en, fb_rd_en, pal_we;
    logic [AW-1:0]    fb_addr;
    logic [IDX_W-1:0] fb_data = '0;
    logic [IDX_W-1:0] pal_addr;
    logic [23:0]      pal_wdata, rgb;
    logic [XW-1:0]    pix_x;
    logic [YW-1:0]    pix_y;
    logic             blank, hsync, vsync, field_odd;

    int n_chk  = 0;
    int n_fail = 0;
    logic [23:0] pal_m [8];

    raster_scan_ctrl #(
        .H_VIS(H_VIS), .V_VIS(V_VIS), .H_RET(H_RET), .V_RET(V_RET), .IDX_W(IDX_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .interlace_en(interlace_en),
        .fb_addr(fb_addr), .fb_rd_en(fb_rd_en), .fb_data(fb_data),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
        .pix_x(pix_x), .pix_y(pix_y), .blank(blank), .hsync(hsync),
        .vsync(vsync), .field_odd(field_odd), .rgb(rgb)
    );

    function automatic logic [IDX_W-1:0] idx_of(int a);
        return IDX_W'((a * 5 + 3) % 8);
    endfunction

    // frame-buffer model: one cycle of read latency
    always @(posedge clk) if (fb_rd_en) fb_data <= idx_of(int'(fb_addr));

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int mode;
        int par;
        rst_n = 1'b0; interlace_en = 1'b0;
        pal_we = 1'b0; pal_addr = '0; pal_wdata = '0;
        for (int i = 0; i < 8; i++) pal_m[i] = {3{8'(i * 36)}};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 blank", int'(blank), 1);
        chk("R1 hsync", int'(hsync), 0);
        chk("R1 vsync", int'(vsync), 0);
        chk("R1 rgb", int'(rgb), 0);
        chk("R1 fb_rd_en", int'(fb_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mode = 0; par = 0;
        for (int f = 0; f < 7; f++) begin
            int nl;
            nl = (mode != 0) ? V_VIS / 2 : V_VIS;
            for (int l = 0; l < nl + V_RET; l++) begin
                for (int x = 0; x < LINE; x++) begin
                    bit vis;
                    int y;
                    @(negedge clk);
                    vis = (l < nl) && (x < H_VIS);
                    y   = (mode != 0) ? 2 * l + par : l;
                    chk("R3/R4 blank", int'(blank), int'(!vis));
                    chk("R3 hsync", int'(hsync), int'(x >= H_VIS + 1 && x <= H_VIS + H_RET - 2));
                    chk("R4 vsync", int'(vsync), int'(l >= nl));
                    chk((mode != 0) ? "R6/R7 field_odd" : "R5/R7 field_odd", int'(field_odd), par);
                    if (vis) begin
                        chk("R2/R8 pix_x", int'(pix_x), x);
                        chk((mode != 0) ? "R6/R7 pix_y" : "R5/R7 pix_y", int'(pix_y), y);
                    end
                    chk("R9/R10 rgb", int'(rgb), vis ? int'(pal_m[idx_of(y * H_VIS + x)]) : 0);
                    pal_we = 1'b0;
                    // R10 writes on a visible pixel, inside vertical retrace, on a line end
                    if (f == 0 && l == 1 && x == 2) begin
                        pal_we = 1'b1; pal_addr = 3'd5; pal_wdata = 24'h123456; pal_m[5] = 24'h123456;
                    end
                    if (f == 2 && l == nl && x == 3) begin
                        pal_we = 1'b1; pal_addr = 3'd0; pal_wdata = 24'hA0B0C0; pal_m[0] = 24'hA0B0C0;
                    end
                    if (f == 4 && l == 0 && x == 7) begin
                        pal_we = 1'b1; pal_addr = 3'd7; pal_wdata = 24'h0F1E2D; pal_m[7] = 24'h0F1E2D;
                    end
                    // R7 mid-frame mode changes
                    if (f == 0 && l == 3 && x == 0) interlace_en = 1'b1;
                    if (f == 1 && l == 1 && x == 0) interlace_en = 1'b0;
                    if (f == 3 && l == 2 && x == 5) interlace_en = 1'b1;
                end
            end
            if (mode != 0 && par == 0) begin
                par = 1;
            end else begin
                par  = 0;
                mode = int'(interlace_en);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule